// File: doc/BRIEF.md
# Flash Boot and Protection Controller

This block decides, once per reset, whether the device starts in boot mode, and then guards every flash access against the protection rules. Three strap pins are captured on the first clock edge after reset is released. The boot-mode result then stays fixed until the next reset. While boot mode is active, software writes a select bit in a mode register to steer instruction fetches to the boot ROM area or to the user ROM area. Outside boot mode, fetches always go to user ROM.

Every access request carries a kind (read, program or erase), a region tag (boot or user), an address and the current programming mode. The block answers one cycle later with grant or deny. Two rules apply. The boot ROM area may only be programmed or erased from the parallel programming mode. A 2-bit protect value locks out every access made in parallel mode unless that value is 11b.

The block keeps a shadow copy of the protect value, loaded from the stored flash field when the straps are captured. Because flash programming can only clear bits, a permitted program of the protect location can only move the shadow towards "locked". Only a permitted erase of the block that holds the location sets the shadow back to 11b. A denied read returns zero data. A denied program or erase also raises an error pulse.

Top module: `flash_boot_guard`

## Requirements
- R1: On the first rising clock edge with rst_n high after a reset, boot_mode becomes 1 if strap_a=1, strap_b=1 and strap_c=0, and 0 for every other strap combination. While rst_n is low, boot_mode, fetch_boot, acc_grant, acc_deny and acc_err are 0.
- R2: After that capture edge, changes on the strap pins have no effect on boot_mode until the next reset.
- R3: When boot mode is entered, fetch_boot is 1, meaning fetches go to the boot ROM area. A register write (reg_we=1) to address MODE_REG_ADDR takes bit SEL_BIT of reg_wdata: 1 selects user ROM (fetch_boot=0) and 0 selects boot ROM (fetch_boot=1). The new value is visible after the write's clock edge. Writes to other addresses leave the select unchanged.
- R4: When boot_mode is 0, fetch_boot stays 0 and writes to the select bit are ignored.
- R5: A program (acc_kind=01) or erase (acc_kind=10) with acc_region=1 (boot area) is granted only while prog_mode=01 (parallel mode). From the other modes it is denied and acc_err is raised. Mode codes are 00 CPU rewrite, 01 parallel, 10 serial and 11 network.
- R6: The shadow protect value is loaded from prot_field on the capture edge, and the prot_field input is ignored after that. While prog_mode=01 and the shadow is not 11b, every access is denied.
- R7: Outside parallel mode the protect value does not block accesses. A read (acc_kind=00) of either region is granted.
- R8: A granted erase in the user region, to an address whose bits above BLK_SHIFT match those of PROT_ADDR, sets the shadow to 11b. A granted program of address PROT_ADDR in the user region ANDs the shadow with acc_wdata[PROT_LSB+1:PROT_LSB], so it can clear bits but never set them. Erasing any other block leaves the shadow unchanged.
- R9: A granted read presents arr_rdata (sampled in the request cycle) on rd_data one cycle after the request. For any other answer, rd_data is 0.
- R10: Exactly one of acc_grant and acc_deny is high in the cycle after each valid request, and neither is high after a cycle without a request. acc_err is high only for a denied program or erase, for one cycle per request. A denied read does not raise acc_err. acc_kind=11 is reserved and is always denied with acc_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_a | input | 1 | Strap pin, must be high for boot mode |
| strap_b | input | 1 | Strap pin, must be high for boot mode |
| strap_c | input | 1 | Strap pin, must be low for boot mode |
| reg_we | input | 1 | CPU register write strobe |
| reg_addr | input | REG_AW | CPU register write address |
| reg_wdata | input | DATA_W | CPU register write data |
| prog_mode | input | 2 | Current programming mode code |
| prot_field | input | 2 | Stored protect field read from flash |
| acc_valid | input | 1 | Access request valid |
| acc_kind | input | 2 | 00 read, 01 program, 10 erase, 11 reserved |
| acc_region | input | 1 | 0 user area, 1 boot area |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | DATA_W | Program data |
| arr_rdata | input | DATA_W | Read data from the array |
| boot_mode | output | 1 | Boot mode flag |
| fetch_boot | output | 1 | 1 steers fetches to the boot ROM area |
| acc_grant | output | 1 | Request permitted (one cycle later) |
| acc_deny | output | 1 | Request refused (one cycle later) |
| acc_err | output | 1 | Error pulse for a refused program or erase |
| rd_data | output | DATA_W | Gated read data |

## Verification
The bench builds the block with a 12-bit address, 256-byte erase blocks (BLK_SHIFT=8), the protect location at 0xFF0 in bits 7:6, and a 4-bit register address with the mode register at 5 and the select in bit 5. These small values let directed addresses hit the protect block, hit a neighbouring block, and miss the mode register with only a few distinct values. The whole lock, clear, relock and unlock sequence is reached within a few dozen cycles.

// File: rtl/fbg_pkg.sv
`timescale 1ns/1ps
package fbg_pkg;

    typedef enum logic [1:0] {
        PM_CPU      = 2'b00,
        PM_PARALLEL = 2'b01,
        PM_SERIAL   = 2'b10,
        PM_NET      = 2'b11
    } prog_mode_e;

    typedef enum logic [1:0] {
        AK_READ  = 2'b00,
        AK_PROG  = 2'b01,
        AK_ERASE = 2'b10,
        AK_RSVD  = 2'b11
    } acc_kind_e;

    localparam logic       RGN_USER = 1'b0;
    localparam logic       RGN_BOOT = 1'b1;
    localparam logic [1:0] PROT_OPEN = 2'b11;

    typedef struct packed {
        logic armed;
        logic boot;
        logic sel_user;
    } strap_st_t;

endpackage

// File: rtl/fbg_strap_latch.sv
`timescale 1ns/1ps
module fbg_strap_latch
    import fbg_pkg::*;
#(
    parameter int REG_AW        = 8,
    parameter int DATA_W        = 8,
    parameter int MODE_REG_ADDR = 8'hB7,
    parameter int SEL_BIT       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_a,
    input  logic              strap_b,
    input  logic              strap_c,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              armed,
    output logic              capture,
    output logic              boot_mode,
    output logic              fetch_boot
);

    localparam logic [REG_AW-1:0] MODE_ADDR = REG_AW'(MODE_REG_ADDR);

    strap_st_t st_d, st_q;
    logic      sel_hit;
    logic      unused_wbits;

    assign unused_wbits = ^reg_wdata;
    assign sel_hit      = reg_we && (reg_addr == MODE_ADDR);

    always_comb begin
        st_d = st_q;
        if (!st_q.armed) begin
            st_d.armed    = 1'b1;
            st_d.boot     = strap_a & strap_b & ~strap_c;
            st_d.sel_user = 1'b0;
        end else if (st_q.boot && sel_hit) begin
            st_d.sel_user = reg_wdata[SEL_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed      = st_q.armed;
    assign capture    = ~st_q.armed;
    assign boot_mode  = st_q.boot;
    assign fetch_boot = st_q.boot & ~st_q.sel_user;

endmodule

// File: rtl/fbg_prot_shadow.sv
`timescale 1ns/1ps
module fbg_prot_shadow
    import fbg_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int BLK_SHIFT = 12,
    parameter int PROT_ADDR = 20'hFFFF0,
    parameter int PROT_LSB  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        prot_field,
    input  logic              ev_grant,
    input  logic [1:0]        ev_kind,
    input  logic              ev_region,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_wdata,
    output logic [1:0]        prot_q
);

    localparam logic [ADDR_W-1:0] P_ADDR = ADDR_W'(PROT_ADDR);
    localparam logic [ADDR_W-1:0] P_BLK  = P_ADDR >> BLK_SHIFT;

    logic [1:0] prot_d;
    logic       blk_hit;
    logic       loc_hit;
    logic       user_ev;
    logic       unused_wbits;

    assign unused_wbits = ^ev_wdata;
    assign blk_hit      = (ev_addr >> BLK_SHIFT) == P_BLK;
    assign loc_hit      = ev_addr == P_ADDR;
    assign user_ev      = ev_grant && (ev_region == RGN_USER);

    always_comb begin
        prot_d = prot_q;
        if (load) begin
            prot_d = prot_field;
        end else if (user_ev) begin
            if (acc_kind_e'(ev_kind) == AK_ERASE && blk_hit)
                prot_d = PROT_OPEN;
            else if (acc_kind_e'(ev_kind) == AK_PROG && loc_hit)
                prot_d = prot_q & ev_wdata[PROT_LSB +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prot_q <= 2'b00;
        else        prot_q <= prot_d;
    end

endmodule

// File: rtl/fbg_access_gate.sv
`timescale 1ns/1ps
module fbg_access_gate
    import fbg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic              acc_region,
    input  logic [1:0]        prog_mode,
    input  logic [1:0]        prot_q,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              grant_now,
    output logic              acc_grant,
    output logic              acc_deny,
    output logic              acc_err,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              grant;
        logic              deny;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } gate_st_t;

    gate_st_t g_d, g_q;
    logic     par_mode;
    logic     locked;
    logic     is_read;
    logic     boot_wr_bad;
    logic     ok;

    always_comb begin
        par_mode    = prog_mode_e'(prog_mode) == PM_PARALLEL;
        locked      = par_mode && (prot_q != PROT_OPEN);
        is_read     = acc_kind_e'(acc_kind) == AK_READ;
        boot_wr_bad = !is_read && (acc_region == RGN_BOOT) && !par_mode;
        ok          = armed && !locked && (acc_kind_e'(acc_kind) != AK_RSVD)
                      && !boot_wr_bad;
        grant_now   = acc_valid && ok;

        g_d.grant = acc_valid && ok;
        g_d.deny  = acc_valid && !ok;
        g_d.err   = acc_valid && !ok && !is_read;
        g_d.rdata = (acc_valid && ok && is_read) ? arr_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign acc_grant = g_q.grant;
    assign acc_deny  = g_q.deny;
    assign acc_err   = g_q.err;
    assign rd_data   = g_q.rdata;

endmodule

// File: rtl/flash_boot_guard.sv
`timescale 1ns/1ps
module flash_boot_guard
    import fbg_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 8,
    parameter int REG_AW        = 8,
    parameter int MODE_REG_ADDR = 8'hB7,
    parameter int SEL_BIT       = 5,
    parameter int BLK_SHIFT     = 12,
    parameter int PROT_ADDR     = 20'hFFFF0,
    parameter int PROT_LSB      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_a,
    input  logic              strap_b,
    input  logic              strap_c,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [1:0]        prog_mode,
    input  logic [1:0]        prot_field,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic              acc_region,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              boot_mode,
    output logic              fetch_boot,
    output logic              acc_grant,
    output logic              acc_deny,
    output logic              acc_err,
    output logic [DATA_W-1:0] rd_data
);

    logic       armed;
    logic       capture;
    logic       grant_now;
    logic [1:0] prot_q;

    fbg_strap_latch #(
        .REG_AW(REG_AW), .DATA_W(DATA_W),
        .MODE_REG_ADDR(MODE_REG_ADDR), .SEL_BIT(SEL_BIT)
    ) u_strap (
        .clk(clk), .rst_n(rst_n),
        .strap_a(strap_a), .strap_b(strap_b), .strap_c(strap_c),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .armed(armed), .capture(capture),
        .boot_mode(boot_mode), .fetch_boot(fetch_boot)
    );

    fbg_prot_shadow #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_SHIFT(BLK_SHIFT),
        .PROT_ADDR(PROT_ADDR), .PROT_LSB(PROT_LSB)
    ) u_prot (
        .clk(clk), .rst_n(rst_n),
        .load(capture), .prot_field(prot_field),
        .ev_grant(grant_now), .ev_kind(acc_kind), .ev_region(acc_region),
        .ev_addr(acc_addr), .ev_wdata(acc_wdata),
        .prot_q(prot_q)
    );

    fbg_access_gate #(
        .DATA_W(DATA_W)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_region(acc_region),
        .prog_mode(prog_mode), .prot_q(prot_q), .arr_rdata(arr_rdata),
        .grant_now(grant_now),
        .acc_grant(acc_grant), .acc_deny(acc_deny), .acc_err(acc_err),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/fbg_checker.sv
`timescale 1ns/1ps
module fbg_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              armed,
    input logic [1:0]        prot_q,
    input logic              boot_mode,
    input logic              fetch_boot,
    input logic              acc_valid,
    input logic [1:0]        acc_kind,
    input logic              acc_region,
    input logic [1:0]        prog_mode,
    input logic              acc_grant,
    input logic              acc_deny,
    input logic              acc_err,
    input logic [DATA_W-1:0] rd_data
);

    a_r2_boot_held: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(armed)) |-> $stable(boot_mode));

    a_r4_user_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_boot |-> boot_mode);

    a_r5_boot_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind != 2'b00 && acc_region && prog_mode != 2'b01)
        |=> (acc_deny && acc_err));

    a_r6_locked_denies: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && prog_mode == 2'b01 && prot_q != 2'b11) |=> acc_deny);

    a_r8_open_only_by_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(armed) && prot_q == 2'b11 && $past(prot_q) != 2'b11)
        |-> $past(acc_valid && acc_kind == 2'b10));

    a_r9_denied_zero: assert property (@(posedge clk) disable iff (!rst_n)
        acc_deny |-> (rd_data == '0));

    a_r10_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_grant && acc_deny));

    a_r10_err_is_deny: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> acc_deny);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !(acc_grant || acc_deny));

    a_r10_answer: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (acc_grant || acc_deny));

endmodule

bind flash_boot_guard fbg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .armed(armed), .prot_q(prot_q),
    .boot_mode(boot_mode), .fetch_boot(fetch_boot),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_region(acc_region),
    .prog_mode(prog_mode), .acc_grant(acc_grant), .acc_deny(acc_deny),
    .acc_err(acc_err), .rd_data(rd_data)
);

// File: tb/flash_boot_guard_test.sv
`timescale 1ns/1ps
module flash_boot_guard_test;

    localparam int AW = 12;
    localparam int DW = 8;
    localparam int RAW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap_a = 1'b0, strap_b = 1'b0, strap_c = 1'b0;
    logic          reg_we = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [1:0]    prog_mode = 2'b00;
    logic [1:0]    prot_field = 2'b11;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_kind = 2'b00;
    logic          acc_region = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic [DW-1:0] arr_rdata = '0;
    logic          boot_mode, fetch_boot, acc_grant, acc_deny, acc_err;
    logic [DW-1:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;

    logic          o_grant, o_deny, o_err, o_err_next;
    logic [DW-1:0] o_rd;

    always #2.5 clk = ~clk;

    flash_boot_guard #(
        .ADDR_W(AW), .DATA_W(DW), .REG_AW(RAW), .MODE_REG_ADDR(5),
        .SEL_BIT(5), .BLK_SHIFT(8), .PROT_ADDR(12'hFF0), .PROT_LSB(6)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .strap_a(strap_a), .strap_b(strap_b), .strap_c(strap_c),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .prog_mode(prog_mode), .prot_field(prot_field),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_region(acc_region),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .arr_rdata(arr_rdata),
        .boot_mode(boot_mode), .fetch_boot(fetch_boot),
        .acc_grant(acc_grant), .acc_deny(acc_deny), .acc_err(acc_err),
        .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic do_reset(input logic a, input logic b, input logic c, input logic [1:0] pf);
        @(negedge clk);
        rst_n = 1'b0;
        strap_a = a; strap_b = b; strap_c = c; prot_field = pf;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic reg_write(input logic [RAW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic access(input logic [1:0] k, input logic r, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input logic [1:0] m, input logic [DW-1:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = k; acc_region = r; acc_addr = a;
        acc_wdata = wd; prog_mode = m; arr_rdata = rd;
        @(posedge clk); #1;
        o_grant = acc_grant; o_deny = acc_deny; o_err = acc_err; o_rd = rd_data;
        @(negedge clk);
        acc_valid = 1'b0;
        @(posedge clk); #1;
        o_err_next = acc_err;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0; strap_a = 1; strap_b = 1; strap_c = 0;
        @(posedge clk); #1;
        chk("R1 boot_mode in reset", boot_mode, 0);
        chk("R1 fetch_boot in reset", fetch_boot, 0);
        chk("R1 grant/deny/err in reset", {acc_grant, acc_deny, acc_err}, 0);
    endtask

    task automatic t_strap_combos();
        do_reset(1, 1, 0, 2'b11);
        chk("R1 boot entered", boot_mode, 1);
        chk("R3 fetch_boot after entry", fetch_boot, 1);
        do_reset(1, 1, 1, 2'b11);
        chk("R1 strap_c high", boot_mode, 0);
        do_reset(0, 1, 0, 2'b11);
        chk("R1 strap_a low", boot_mode, 0);
        do_reset(1, 0, 0, 2'b11);
        chk("R1 strap_b low", boot_mode, 0);
    endtask

    task automatic t_strap_hold();
        do_reset(1, 1, 0, 2'b11);
        @(negedge clk); strap_a = 0; strap_b = 0; strap_c = 1;
        repeat (4) @(posedge clk); #1;
        chk("R2 boot held after strap change", boot_mode, 1);
        do_reset(0, 0, 1, 2'b11);
        @(negedge clk); strap_a = 1; strap_b = 1; strap_c = 0;
        repeat (4) @(posedge clk); #1;
        chk("R2 normal held after strap change", boot_mode, 0);
    endtask

    task automatic t_select();
        do_reset(1, 1, 0, 2'b11);
        reg_write(4'h5, 8'h20);
        chk("R3 select user", fetch_boot, 0);
        reg_write(4'h5, 8'hDF);
        chk("R3 select boot", fetch_boot, 1);
        reg_write(4'h4, 8'hFF);
        chk("R3 other address ignored", fetch_boot, 1);
    endtask

    task automatic t_nonboot_select();
        do_reset(1, 0, 0, 2'b11);
        reg_write(4'h5, 8'h00);
        chk("R4 select ignored outside boot", fetch_boot, 0);
        reg_write(4'h5, 8'h20);
        reg_write(4'h5, 8'h00);
        chk("R4 still user fetch", fetch_boot, 0);
    endtask

    task automatic t_boot_region();
        do_reset(0, 0, 0, 2'b11);
        access(2'b01, 1'b1, 12'h010, 8'h00, 2'b00, 8'h00);
        chk("R5 cpu program boot deny", {o_grant, o_deny, o_err}, 3'b011);
        chk("R10 err one cycle", o_err_next, 0);
        access(2'b10, 1'b1, 12'h010, 8'h00, 2'b10, 8'h00);
        chk("R5 serial erase boot deny", {o_grant, o_deny, o_err}, 3'b011);
        access(2'b01, 1'b1, 12'h010, 8'h00, 2'b01, 8'h00);
        chk("R5 parallel program boot grant", {o_grant, o_deny, o_err}, 3'b100);
        access(2'b01, 1'b0, 12'h010, 8'h00, 2'b00, 8'h00);
        chk("R5 cpu program user grant", {o_grant, o_deny, o_err}, 3'b100);
        access(2'b11, 1'b0, 12'h010, 8'h00, 2'b00, 8'h00);
        chk("R10 reserved kind denied", {o_grant, o_deny, o_err}, 3'b011);
    endtask

    task automatic t_protect();
        do_reset(0, 0, 0, 2'b10);
        access(2'b00, 1'b0, 12'h123, 8'h00, 2'b01, 8'hA5);
        chk("R6 locked parallel read deny", {o_grant, o_deny}, 2'b01);
        chk("R9 denied read zero", o_rd, 0);
        chk("R10 denied read no err", o_err, 0);
        access(2'b01, 1'b0, 12'h123, 8'h00, 2'b01, 8'h00);
        chk("R6 locked parallel program deny", {o_deny, o_err}, 2'b11);
        access(2'b00, 1'b1, 12'h123, 8'h00, 2'b10, 8'hA5);
        chk("R7 serial read grant", o_grant, 1);
        chk("R9 granted read data", o_rd, 8'hA5);
        access(2'b10, 1'b0, 12'h1F3, 8'h00, 2'b10, 8'h00);
        chk("R8 other block erase grant", o_grant, 1);
        access(2'b00, 1'b0, 12'h123, 8'h00, 2'b01, 8'h3C);
        chk("R8 still locked after other erase", o_deny, 1);
        access(2'b10, 1'b0, 12'hF23, 8'h00, 2'b10, 8'h00);
        chk("R8 protect block erase grant", o_grant, 1);
        access(2'b00, 1'b0, 12'h123, 8'h00, 2'b01, 8'h3C);
        chk("R8 unlocked after erase", o_grant, 1);
        chk("R9 data after unlock", o_rd, 8'h3C);
    endtask

    task automatic t_prog_clear();
        do_reset(0, 0, 0, 2'b11);
        @(negedge clk); prot_field = 2'b00;
        access(2'b00, 1'b0, 12'h200, 8'h00, 2'b01, 8'h11);
        chk("R6 prot_field ignored after capture", o_grant, 1);
        access(2'b01, 1'b0, 12'hFF0, 8'h7F, 2'b00, 8'h00);
        chk("R8 program protect location grant", o_grant, 1);
        access(2'b00, 1'b0, 12'h200, 8'h00, 2'b01, 8'h11);
        chk("R8 program clears to locked", o_deny, 1);
        access(2'b01, 1'b0, 12'hFF0, 8'hFF, 2'b11, 8'h00);
        access(2'b00, 1'b0, 12'h200, 8'h00, 2'b01, 8'h11);
        chk("R8 program cannot set bits", o_deny, 1);
        access(2'b10, 1'b0, 12'hF00, 8'h00, 2'b00, 8'h00);
        access(2'b00, 1'b0, 12'h200, 8'h00, 2'b01, 8'h11);
        chk("R8 cpu erase reopens", o_grant, 1);
        @(posedge clk); #1;
        chk("R10 idle quiet", {acc_grant, acc_deny, acc_err}, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        t_reset_state();
        t_strap_combos();
        t_strap_hold();
        t_select();
        t_nonboot_select();
        t_boot_region();
        t_protect();
        t_prog_clear();
        finish_up();
    end

endmodule